// File: doc/BRIEF.md
# Display Memory Serial Packet Decoder

This block sits between a serial slave front end (I2C or SPI) and the character and control memory of an on-screen display. The front end hands over one received byte at a time with a valid strobe, and marks the start of each transfer with a separate strobe. The decoder turns the byte stream into single-cycle writes to a memory of 16 rows by 32 columns. Columns 0 to 29 of rows 0 to 14 hold character codes. Columns 30 and 31 of each of those rows hold per-row control. Row 15 holds the window, frame and pulse-width control registers. The decoder does not treat any of these regions differently; it only forms addresses.

Three packet styles can be used. In the first, every data byte is preceded by a row byte and a column byte. In the second, one row byte is followed by column/data pairs. In the third, a row byte and a column byte are sent once, and every later byte is data written to consecutive locations. Address bytes are recognised by their top bits. Data bytes are taken whole, including a set top bit, so a character code can carry its colour-select bit.

Top module: `osd_pkt_decoder`

## Requirements
- R1: During and after reset, wr_en is 0 and the decoder waits for a row byte.
- R2: While a row or column byte is expected, a byte with bit 7 = 1 is a row byte. Its bits 3:0 become the current row, and it causes no write.
- R3: After a row byte, a byte with bit 7 = 0 and bit 6 = 0 is a column byte. Its bits 4:0 become the current column. The next byte is written whole (all 8 bits, bit 7 included) to that row and column.
- R4: After a data write in single mode, a column byte may follow directly. The next data byte is then written to the same row at the new column.
- R5: After a data write in single mode, a row byte may follow. It sets a new row, and the decoder then expects a column byte.
- R6: A column byte with bit 7 = 0 and bit 6 = 1 enters burst mode. Each later valid byte is written to the current address, and the column then advances by one.
- R7: In burst mode, after column 31 the column goes to 0 and the row advances by one. Row 15 is followed by row 0.
- R8: In burst mode, a byte with bit 7 = 1 is written as data. Only a start-of-transfer strobe leaves burst mode.
- R9: A start-of-transfer strobe returns the decoder to waiting for a row byte. A byte valid in the same cycle is decoded as the first byte of the new transfer.
- R10: While a row byte is expected, a byte with bit 7 = 0 is dropped, and no write results.
- R11: A write appears on the outputs exactly one clock after the byte that causes it. wr_en is a one-cycle pulse per data byte.
- R12: Cycles with byte_vld = 0 change nothing, whatever byte_dat holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | byte_dat holds a received byte this cycle |
| byte_sof | input | 1 | Start of a new transfer |
| byte_dat | input | 8 | Received byte |
| wr_en | output | 1 | Memory write strobe |
| wr_row | output | 4 | Write row address |
| wr_col | output | 5 | Write column address |
| wr_data | output | 8 | Write data |

## Verification
The hardest case to reach is the double wrap in burst mode, where the address passes from row 15 column 31 to row 0 column 0. The stimulus reaches it by opening a burst at row 15 column 30 and sending several bytes. Some of those bytes have bit 7 set, so the same run also shows that address-like bytes cannot end a burst. A long pseudo-random phase then mixes start strobes, idle cycles and arbitrary bytes. This drives the decoder through every state change, including a start strobe that arrives together with a byte and one that cuts a burst short. Every clock is compared against a behavioural model.

// File: rtl/osd_pkt_decoder.sv
module osd_pkt_decoder #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_sof,
  input  logic [DATA_W-1:0] byte_dat,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);
  localparam int ADDR_W = ROW_W + COL_W;

  typedef enum logic [1:0] {
    WAIT_ROW  = 2'd0,
    WAIT_COL  = 2'd1,
    WAIT_DATA = 2'd2,
    BURST     = 2'd3
  } st_t;

  st_t st, st_cur;
  logic [ADDR_W-1:0] ptr, wr_addr;
  logic is_row, is_burst;

  assign st_cur   = byte_sof ? WAIT_ROW : st;
  assign is_row   = byte_dat[DATA_W-1];
  assign is_burst = byte_dat[DATA_W-2];
  assign wr_row   = wr_addr[ADDR_W-1:COL_W];
  assign wr_col   = wr_addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WAIT_ROW;
      ptr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (byte_sof) st <= WAIT_ROW;
      if (byte_vld) begin
        unique case (st_cur)
          WAIT_ROW: if (is_row) begin
            ptr[ADDR_W-1:COL_W] <= byte_dat[ROW_W-1:0];
            st <= WAIT_COL;
          end
          WAIT_COL: begin
            if (is_row) ptr[ADDR_W-1:COL_W] <= byte_dat[ROW_W-1:0];
            else begin
              ptr[COL_W-1:0] <= byte_dat[COL_W-1:0];
              st <= is_burst ? BURST : WAIT_DATA;
            end
          end
          WAIT_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= byte_dat;
            st      <= WAIT_COL;
          end
          BURST: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= byte_dat;
            ptr     <= ptr + 1'b1;
          end
          default: st <= WAIT_ROW;
        endcase
      end
    end
  end
endmodule

module osd_pkt_decoder_chk #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              byte_sof,
  input logic [DATA_W-1:0] byte_dat,
  input logic              wr_en,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic [1:0]        st_q
);
  localparam int ADDR_W = ROW_W + COL_W;
  logic [ADDR_W-1:0] addr;
  assign addr = {wr_row, wr_col};

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !wr_en);

  // R11
  write_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_vld));

  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !wr_en);

  // R6 R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> addr == $past(addr) + 1'b1);

  // R10 R9
  drop_col_when_row_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_dat[DATA_W-1] && (byte_sof || st_q == 2'd0)) |=> !wr_en);

  // R8
  burst_takes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_sof && st_q == 2'd3) |=> wr_en);
endmodule

bind osd_pkt_decoder osd_pkt_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_dat(byte_dat),
  .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .st_q(st)
);

// File: tb/osd_pkt_decoder_tb.sv
module osd_pkt_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic       byte_sof = 1'b0;
  logic [7:0] byte_dat = 8'h00;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  osd_pkt_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_dat(byte_dat),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  // behavioural reference: 0 wait row, 1 wait column, 2 wait data, 3 burst
  int mstate = 0, mrow = 0, mcol = 0;
  int e_en = 0, e_row = 0, e_col = 0, e_dat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mstate = 0; mrow = 0; mcol = 0; e_en = 0;
    end else begin
      e_en = 0;
      if (byte_sof) mstate = 0;
      if (byte_vld) begin
        if (mstate == 0) begin
          if (byte_dat[7]) begin mrow = byte_dat[3:0]; mstate = 1; end
        end else if (mstate == 1) begin
          if (byte_dat[7]) mrow = byte_dat[3:0];
          else begin mcol = byte_dat[4:0]; mstate = byte_dat[6] ? 3 : 2; end
        end else begin
          e_en = 1; e_row = mrow; e_col = mcol; e_dat = byte_dat;
          if (mstate == 2) mstate = 1;
          else begin
            mcol = mcol + 1;
            if (mcol == 32) begin mcol = 0; mrow = (mrow + 1) % 16; end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (wr_en !== (e_en != 0)) begin
      fails++;
      $display("FAIL %s: wr_en actual %0b expected %0d", cur_req, wr_en, e_en);
    end else if (e_en != 0 && (wr_row != e_row || wr_col != e_col || wr_data != e_dat)) begin
      fails++;
      $display("FAIL %s: write actual r%0d c%0d d%02h expected r%0d c%0d d%02h",
               cur_req, wr_row, wr_col, wr_data, e_row, e_col, e_dat);
    end
  end

  task automatic send(input logic [7:0] b, input logic sof);
    byte_vld = 1'b1; byte_sof = sof; byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0; byte_sof = 1'b0; byte_dat = 8'h00;
  endtask

  task automatic chk(input logic en, input int r, input int c, input int d, input string tag);
    vectors++;
    if (wr_en !== en || (en && (wr_row != r || wr_col != c || wr_data != d))) begin
      fails++;
      $display("FAIL %s: actual en%0b r%0d c%0d d%02h expected en%0b r%0d c%0d d%02h",
               tag, wr_en, wr_row, wr_col, wr_data, en, r, c, d);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(1'b0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, 0, 0, 0, "R1");

    cur_req = "R10";
    send(8'h05, 1'b1); chk(1'b0, 0, 0, 0, "R10");
    send(8'h41, 1'b0); chk(1'b0, 0, 0, 0, "R10");

    cur_req = "R3";
    send(8'h83, 1'b0); chk(1'b0, 0, 0, 0, "R2");
    send(8'h07, 1'b0);
    send(8'hC5, 1'b0); chk(1'b1, 3, 7, 8'hC5, "R3");

    cur_req = "R4";
    send(8'h1F, 1'b0);
    send(8'h2A, 1'b0); chk(1'b1, 3, 31, 8'h2A, "R4");

    cur_req = "R5";
    send(8'h8E, 1'b0);
    send(8'h8A, 1'b0); chk(1'b0, 0, 0, 0, "R2");
    send(8'h1E, 1'b0);
    send(8'h91, 1'b0); chk(1'b1, 10, 30, 8'h91, "R5");

    cur_req = "R6";
    send(8'h80, 1'b1);
    send(8'h5D, 1'b0);
    send(8'h11, 1'b0); chk(1'b1, 0, 29, 8'h11, "R6");
    send(8'h22, 1'b0); chk(1'b1, 0, 30, 8'h22, "R6");
    cur_req = "R12";
    byte_dat = 8'hFF; @(negedge clk); chk(1'b0, 0, 0, 0, "R12");
    byte_dat = 8'h00;
    cur_req = "R8";
    send(8'h85, 1'b0); chk(1'b1, 0, 31, 8'h85, "R8");
    send(8'h33, 1'b0); chk(1'b1, 1, 0, 8'h33, "R7");

    cur_req = "R7";
    send(8'h8F, 1'b1);
    send(8'h5E, 1'b0);
    send(8'hA0, 1'b0); chk(1'b1, 15, 30, 8'hA0, "R7");
    send(8'hA1, 1'b0); chk(1'b1, 15, 31, 8'hA1, "R7");
    send(8'hA2, 1'b0); chk(1'b1, 0, 0, 8'hA2, "R7");

    cur_req = "R9";
    send(8'h03, 1'b1); chk(1'b0, 0, 0, 0, "R9");
    send(8'h44, 1'b0); chk(1'b0, 0, 0, 0, "R9");
    send(8'h82, 1'b0);
    send(8'h04, 1'b0);
    send(8'h77, 1'b0); chk(1'b1, 2, 4, 8'h77, "R9");

    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      byte_vld = lfsr[0] | lfsr[1];
      byte_sof = (lfsr[5:2] == 4'd0);
      byte_dat = lfsr[15:8] ^ {lfsr[3], 7'd0};
      @(negedge clk);
    end
    byte_vld = 1'b0; byte_sof = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule